// File: doc/BRIEF.md
# H-Bridge Motor Control Sequencer

This block is the digital control core of a full-bridge DC motor driver. Two command inputs pick one of four actions: drive forward, drive reverse, brake, or coast. The block turns that choice into four registered gate enables, one for each high-side and low-side switch of the two bridge legs. Current sensing, thermal sensing, supply monitoring and short detection all happen in analog circuits elsewhere. Each of them reaches this block as a synchronous one-bit flag.

When both inputs stay low for a set number of cycles, the block drops into a low-power idle state. The first drive or brake command brings it out again. After that exit, a fixed hold-off stands in for the time the charge pump needs to come up. Only then may any switch turn on. While the bridge drives a diagonal, a current trip opens both switches of that diagonal, which is mixed decay. The switches stay open for a fixed off-time, and the diagonal comes back if the command still asks for it.

A detected output short sets a fault latch that holds all switches open. Only a reset or an exit from the idle state clears it. Over-temperature and undervoltage flags hold the bridge off for as long as they are asserted. Every move from one conducting pattern to another passes through a dead time with all gates low. Power-on reset puts the block in the idle state, so the first command after power-up also waits out the hold-off.

Top module: `hb_motor_ctrl`

## Requirements
- R1: The command inputs pass through two synchronising flip-flops, then one gate register. From an idle bridge with no dead time pending, a new command changes the gates after the third rising clock edge following the change, and not after the second.
- R2: The command encoding is {in_a, in_b}. 10 selects forward, which turns on gate_hi_a and gate_lo_b. 01 selects reverse, which turns on gate_hi_b and gate_lo_a. 11 selects brake, which turns on gate_lo_a and gate_lo_b. 00 selects coast, which turns every gate off. No other gate combination ever appears.
- R3: The high-side and low-side gates of one leg are never on together. The gate outputs never move straight from one conducting pattern to a different one.
- R4: When the gates leave a conducting pattern, they stay all-off for at least DEAD_CYCLES cycles before any conducting pattern appears. For a reversal, the new pattern appears DEAD_CYCLES+1 edges after the old one is dropped.
- R5: The idle state (idle_mode = 1) is entered after the synchronised command has been coast for STBY_CYCLES consecutive cycles. That is two edges later than STBY_CYCLES from the input change. Any non-coast command before then restarts the count.
- R6: Reset puts the block in the idle state with all gates off. A non-coast command leaves the idle state on the third edge after the change. All gates then stay off for WAKE_CYCLES further edges, and the commanded pattern appears on the next edge.
- R7: A trip_flag seen while a diagonal (forward or reverse) conducts sets chopping = 1 at that edge and turns the gates off at the next edge. chopping lasts TOFF_CYCLES cycles. The diagonal returns one edge after chopping ends if the command is unchanged.
- R8: trip_flag has no effect during brake or coast. A trip during an active off-time does not restart or lengthen it.
- R9: short_flag sets fault_latched at the next edge and turns all gates off. The latch survives command changes and coast periods shorter than the idle entry time. It clears on the edge that leaves the idle state. If a short and an idle exit fall on the same edge, the latch ends up set.
- R10: While overtemp_flag is high at a clock edge, all gates are off after that edge. Once it drops, the commanded pattern resumes as soon as the dead time allows.
- R11: While undervolt_flag is high at a clock edge, all gates are off after that edge. Once it drops, the commanded pattern resumes as soon as the dead time allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Command input A (asynchronous) |
| in_b | input | 1 | Command input B (asynchronous) |
| trip_flag | input | 1 | Current-sense comparator tripped |
| short_flag | input | 1 | Output short detected |
| overtemp_flag | input | 1 | Die over temperature, hysteresis applied outside |
| undervolt_flag | input | 1 | Supply below operating threshold |
| gate_hi_a | output | 1 | High-side switch enable, leg A |
| gate_lo_a | output | 1 | Low-side switch enable, leg A |
| gate_hi_b | output | 1 | High-side switch enable, leg B |
| gate_lo_b | output | 1 | Low-side switch enable, leg B |
| idle_mode | output | 1 | Low-power idle state active |
| fault_latched | output | 1 | Short-circuit fault latch set |
| chopping | output | 1 | Fixed off-time after a current trip in progress |

## Verification
The fault latch and the idle-exit path can act on the same clock edge. One wants to set the latch and the other wants to clear it. The bench provokes this by issuing a drive command from the idle state and raising short_flag only during the cycle before the exit edge. It then expects idle_mode low, fault_latched high, and the gates still off once the hold-off has expired. A second overlap is a trip that arrives in the middle of an active off-time. The bench judges it by the exact edge on which the diagonal returns.

// File: rtl/hb_pkg.sv
// Package hb_pkg
// Shared command and gate-pattern types for the H-bridge sequencer.
// Assumes the command code is {in_a, in_b} after synchronisation.
package hb_pkg;

    typedef enum logic [1:0] {
        CMD_COAST = 2'b00,
        CMD_REV   = 2'b01,
        CMD_FWD   = 2'b10,
        CMD_BRAKE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        PAT_OFF   = 2'd0,
        PAT_FWD   = 2'd1,
        PAT_REV   = 2'd2,
        PAT_BRAKE = 2'd3
    } pat_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gates_t;

    // Map a conducting pattern onto the four switch enables.
    function automatic gates_t pat_gates(input pat_e p);
        gates_t g;
        g = '0;
        case (p)
            PAT_FWD:   begin g.hi_a = 1'b1; g.lo_b = 1'b1; end
            PAT_REV:   begin g.hi_b = 1'b1; g.lo_a = 1'b1; end
            PAT_BRAKE: begin g.lo_a = 1'b1; g.lo_b = 1'b1; end
            default:   g = '0;
        endcase
        return g;
    endfunction

    // Map a decoded command onto the pattern it requests.
    function automatic pat_e cmd_pattern(input cmd_e c);
        pat_e p;
        case (c)
            CMD_FWD:   p = PAT_FWD;
            CMD_REV:   p = PAT_REV;
            CMD_BRAKE: p = PAT_BRAKE;
            default:   p = PAT_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hb_in_sync.sv
// Module hb_in_sync
// Multi-stage synchroniser for asynchronous command inputs.
// Assumes STAGES >= 1; the reset value of every stage is zero.
module hb_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: capture the input directly.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            // Shift the input through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/hb_standby_ctrl.sv
// Module hb_standby_ctrl
// Tracks the low-power idle state: timed entry on a sustained coast
// command, exit on any other command, followed by a fixed hold-off that
// models the charge pump coming up. Assumes STBY_CYCLES >= 1.
// Reset enters the idle state.
module hb_standby_ctrl
    import hb_pkg::*;
#(
    parameter int STBY_CYCLES = 250000,
    parameter int WAKE_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    output logic idle_q,
    output logic wake_busy,
    output logic idle_exit
);
    localparam int IW = $clog2(STBY_CYCLES + 2);
    localparam int WW = $clog2(WAKE_CYCLES + 2);
    localparam logic [IW-1:0] IDLE_LAST = IW'(STBY_CYCLES - 1);
    localparam logic [WW-1:0] WAKE_INIT = WW'(WAKE_CYCLES);

    logic [IW-1:0] idle_cnt_q;
    logic [WW-1:0] wake_cnt_q;

    assign idle_exit = idle_q && (cmd != CMD_COAST);
    assign wake_busy = (wake_cnt_q != '0);

    // Idle state and the consecutive-coast counter that leads into it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q     <= 1'b1;
            idle_cnt_q <= '0;
        end else if (idle_q) begin
            idle_cnt_q <= '0;
            if (idle_exit) idle_q <= 1'b0;
        end else if (cmd == CMD_COAST) begin
            if (idle_cnt_q == IDLE_LAST) begin
                idle_q     <= 1'b1;
                idle_cnt_q <= '0;
            end else begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end else begin
            idle_cnt_q <= '0;
        end
    end

    // Hold-off counter started by each idle exit.
    always_ff @(posedge clk) begin
        if (!rst_n)               wake_cnt_q <= '0;
        else if (idle_exit)       wake_cnt_q <= WAKE_INIT;
        else if (wake_cnt_q != 0) wake_cnt_q <= wake_cnt_q - 1'b1;
    end

    // R5: idle is only entered out of a coast command
    a_r5_entry_from_coast: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_q) |-> ($past(cmd) == CMD_COAST))
        else $error("idle entered without coast");

    // R5: a non-coast command clears the coast count
    a_r5_abort_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && cmd != CMD_COAST) |=> (idle_cnt_q == '0))
        else $error("coast count not restarted");

    // R6: an exit leaves the idle state on the next edge
    a_r6_exit_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exit |=> !idle_q)
        else $error("idle exit ignored");

endmodule

// File: rtl/hb_chop_timer.sv
// Module hb_chop_timer
// Fixed off-time timer for current-trip chopping. A trip starts the
// timer only while a diagonal conducts and no off-time runs; the timer
// is dropped when the drive command goes away or the bridge is inhibited.
module hb_chop_timer
    import hb_pkg::*;
#(
    parameter int TOFF_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic trip,
    input  logic enable,
    input  logic conducting,
    output logic chopping
);
    localparam int TW = $clog2(TOFF_CYCLES + 2);
    localparam logic [TW-1:0] TOFF_INIT = TW'(TOFF_CYCLES);

    logic [TW-1:0] off_cnt_q;
    logic          is_drive;

    assign is_drive = (cmd == CMD_FWD) || (cmd == CMD_REV);
    assign chopping = (off_cnt_q != '0);

    // Off-time countdown: load on a qualified trip, clear on loss of drive.
    always_ff @(posedge clk) begin
        if (!rst_n)                     off_cnt_q <= '0;
        else if (!enable || !is_drive)  off_cnt_q <= '0;
        else if (off_cnt_q != '0)       off_cnt_q <= off_cnt_q - 1'b1;
        else if (trip && conducting)    off_cnt_q <= TOFF_INIT;
    end

    // R8: a running off-time only counts down, a trip never extends it
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (chopping && enable && is_drive) |=> (off_cnt_q == $past(off_cnt_q) - 1'b1))
        else $error("off-time restarted");

    // R8: no trip starts an off-time while braking or coasting
    a_r8_drive_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_drive) |=> !chopping)
        else $error("chop outside drive");

endmodule

// File: rtl/hb_gate_seq.sv
// Module hb_gate_seq
// Registers the active gate pattern and enforces an all-off dead time
// whenever a conducting pattern is left. Assumes the target pattern is
// already reduced to PAT_OFF by every inhibit source.
module hb_gate_seq
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  pat_e   target,
    output pat_e   pat_q,
    output gates_t gates
);
    localparam int DW = $clog2(DEAD_CYCLES + 2);
    localparam logic [DW-1:0] DEAD_INIT = DW'(DEAD_CYCLES);

    logic [DW-1:0] dead_cnt_q;

    assign gates = pat_gates(pat_q);

    // Pattern sequencing: drop to off on any change, then wait the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q      <= PAT_OFF;
            dead_cnt_q <= '0;
        end else if (pat_q != PAT_OFF) begin
            if (target != pat_q) begin
                pat_q      <= PAT_OFF;
                dead_cnt_q <= DEAD_INIT;
            end
        end else if (dead_cnt_q != '0) begin
            dead_cnt_q <= dead_cnt_q - 1'b1;
        end else if (target != PAT_OFF) begin
            pat_q <= target;
        end
    end

    // Checker state: length of the current all-off run, saturating.
    logic [DW-1:0] off_run_q;
    logic          seen_on_q;

    // Count cycles spent off since the last conducting pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run_q <= '0;
            seen_on_q <= 1'b0;
        end else if (pat_q == PAT_OFF) begin
            if (off_run_q != DEAD_INIT) off_run_q <= off_run_q + 1'b1;
        end else begin
            off_run_q <= '0;
            seen_on_q <= 1'b1;
        end
    end

    // R3: never step directly between two different conducting patterns
    a_r3_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q != PAT_OFF && $past(pat_q) != PAT_OFF) |-> (pat_q == $past(pat_q)))
        else $error("direct pattern swap");

    // R4: a conducting pattern follows at least DEAD_CYCLES off cycles
    a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_on_q && $past(pat_q) == PAT_OFF && pat_q != PAT_OFF) |-> (off_run_q >= DEAD_INIT))
        else $error("dead time too short");

endmodule

// File: rtl/hb_motor_ctrl.sv
// Module hb_motor_ctrl
// Top of the H-bridge control sequencer: synchronises the two command
// inputs, runs idle entry and wake hold-off, current-trip chopping, the
// sticky short-circuit fault latch and the thermal/supply inhibits, and
// drives four registered gate enables with dead time between patterns.
// Assumes all flag inputs are already synchronous to clk.
module hb_motor_ctrl
    import hb_pkg::*;
#(
    parameter int CLK_HZ      = 250000000,
    parameter int STBY_CYCLES = CLK_HZ / 1000,
    parameter int WAKE_CYCLES = CLK_HZ / 5000,
    parameter int TOFF_CYCLES = CLK_HZ / 40000,
    parameter int DEAD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic trip_flag,
    input  logic short_flag,
    input  logic overtemp_flag,
    input  logic undervolt_flag,
    output logic gate_hi_a,
    output logic gate_lo_a,
    output logic gate_hi_b,
    output logic gate_lo_b,
    output logic idle_mode,
    output logic fault_latched,
    output logic chopping
);
    logic [1:0] in_sync;
    cmd_e       cmd;
    logic       idle_q;
    logic       wake_busy;
    logic       idle_exit;
    logic       fault_q;
    logic       inhibit;
    logic       chop_on;
    logic       conducting;
    pat_e       target;
    pat_e       pat_q;
    gates_t     gates;

    hb_in_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_a, in_b}),
        .q     (in_sync)
    );

    assign cmd = cmd_e'(in_sync);

    hb_standby_ctrl #(
        .STBY_CYCLES (STBY_CYCLES),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_standby (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .idle_q    (idle_q),
        .wake_busy (wake_busy),
        .idle_exit (idle_exit)
    );

    // Sticky short-circuit latch: set wins over a simultaneous idle exit.
    always_ff @(posedge clk) begin
        if (!rst_n)          fault_q <= 1'b0;
        else if (short_flag) fault_q <= 1'b1;
        else if (idle_exit)  fault_q <= 1'b0;
    end

    assign inhibit    = fault_q | overtemp_flag | undervolt_flag | idle_q | wake_busy;
    assign conducting = (pat_q == PAT_FWD) || (pat_q == PAT_REV);

    hb_chop_timer #(
        .TOFF_CYCLES (TOFF_CYCLES)
    ) u_chop (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .trip       (trip_flag),
        .enable     (!inhibit),
        .conducting (conducting),
        .chopping   (chop_on)
    );

    // Requested pattern: off under any inhibit or off-time, else the command.
    always_comb begin
        if (inhibit || chop_on) target = PAT_OFF;
        else                    target = cmd_pattern(cmd);
    end

    hb_gate_seq #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_gates (
        .clk    (clk),
        .rst_n  (rst_n),
        .target (target),
        .pat_q  (pat_q),
        .gates  (gates)
    );

    assign gate_hi_a     = gates.hi_a;
    assign gate_lo_a     = gates.lo_a;
    assign gate_hi_b     = gates.hi_b;
    assign gate_lo_b     = gates.lo_b;
    assign idle_mode     = idle_q;
    assign fault_latched = fault_q;
    assign chopping      = chop_on;

    // R3: leg A switches never conduct together
    a_r3_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a))
        else $error("leg A shoot-through");

    // R3: leg B switches never conduct together
    a_r3_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_b && gate_lo_b))
        else $error("leg B shoot-through");

    // R6: idle or hold-off forces every gate off
    a_r6_holdoff_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q || wake_busy) |=> (gates == '0))
        else $error("gates on during idle or hold-off");

    // R7: an off-time forces every gate off on the following edge
    a_r7_chop_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        chop_on |=> (gates == '0))
        else $error("gates on during off-time");

    // R9: the latched fault keeps every gate off
    a_r9_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |=> (gates == '0))
        else $error("gates on with fault latched");

    // R9: the fault latch only clears on an idle exit
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !idle_exit) |=> fault_q)
        else $error("fault cleared without idle exit");

    // R10: over-temperature forces every gate off
    a_r10_overtemp_off: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp_flag |=> (gates == '0))
        else $error("gates on at over-temperature");

    // R11: undervoltage forces every gate off
    a_r11_undervolt_off: assert property (@(posedge clk) disable iff (!rst_n)
        undervolt_flag |=> (gates == '0))
        else $error("gates on at undervoltage");

endmodule

// File: tb/hb_motor_ctrl_bench.sv
module hb_motor_ctrl_bench;

    localparam int STBY = 200;
    localparam int WAKE = 40;
    localparam int TOFF = 24;
    localparam int DEAD = 4;
    localparam int QUIET_MIN = WAKE + TOFF + DEAD + 8;

    localparam logic [3:0] G_OFF = 4'b0000;
    localparam logic [3:0] G_FWD = 4'b1001;
    localparam logic [3:0] G_REV = 4'b0110;
    localparam logic [3:0] G_BRK = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0;
    logic trip_flag = 1'b0, short_flag = 1'b0;
    logic overtemp_flag = 1'b0, undervolt_flag = 1'b0;
    logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;
    logic idle_mode, fault_latched, chopping;
    logic [3:0] g;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign g = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};

    hb_motor_ctrl #(
        .STBY_CYCLES (STBY),
        .WAKE_CYCLES (WAKE),
        .TOFF_CYCLES (TOFF),
        .DEAD_CYCLES (DEAD)
    ) u_hb_motor_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_a           (in_a),
        .in_b           (in_b),
        .trip_flag      (trip_flag),
        .short_flag     (short_flag),
        .overtemp_flag  (overtemp_flag),
        .undervolt_flag (undervolt_flag),
        .gate_hi_a      (gate_hi_a),
        .gate_lo_a      (gate_lo_a),
        .gate_hi_b      (gate_hi_b),
        .gate_lo_b      (gate_lo_b),
        .idle_mode      (idle_mode),
        .fault_latched  (fault_latched),
        .chopping       (chopping)
    );

    function automatic logic [3:0] exp_gates(input logic a, input logic b);
        case ({a, b})
            2'b10:   return G_FWD;
            2'b01:   return G_REV;
            2'b11:   return G_BRK;
            default: return G_OFF;
        endcase
    endfunction

    function automatic bit legal_pattern(input logic [3:0] v);
        return (v == G_OFF) || (v == G_FWD) || (v == G_REV) || (v == G_BRK);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic set_in(input logic a, input logic b);
        in_a = a;
        in_b = b;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // Reset state (R6)
        tick(5);
        chk("R6 gates in reset", g, G_OFF);
        rst_n = 1'b1;
        tick(1);
        chk("R6 idle after reset", idle_mode, 1);
        chk("R6 gates off after reset", g, G_OFF);
        chk("R9 fault clear after reset", fault_latched, 0);
        chk("R7 no chopping after reset", chopping, 0);

        // Wake hold-off (R6, R2 forward)
        set_in(1, 0);
        tick(2);
        chk("R6 idle still before exit edge", idle_mode, 1);
        tick(1);
        chk("R6 idle left on third edge", idle_mode, 0);
        chk("R6 gates off at exit", g, G_OFF);
        tick(WAKE);
        chk("R6 gates off at end of hold-off", g, G_OFF);
        tick(1);
        chk("R2 forward pattern after hold-off", g, G_FWD);

        // Reversal with dead time (R1, R4, R2 reverse)
        set_in(0, 1);
        tick(2);
        chk("R1 no change after two edges", g, G_FWD);
        tick(1);
        chk("R4 off after old pattern dropped", g, G_OFF);
        tick(DEAD);
        chk("R4 still off through dead time", g, G_OFF);
        tick(1);
        chk("R2 reverse pattern", g, G_REV);

        // Brake and trip ignored during brake (R2, R8)
        set_in(1, 1);
        tick(3 + DEAD + 2);
        chk("R2 brake pattern", g, G_BRK);
        trip_flag = 1'b1;
        tick(1);
        trip_flag = 1'b0;
        tick(2);
        chk("R8 trip ignored in brake gates", g, G_BRK);
        chk("R8 trip ignored in brake chopping", chopping, 0);

        // Coast, then sync latency from a settled off state (R2, R1)
        set_in(0, 0);
        tick(3);
        chk("R2 coast all off", g, G_OFF);
        tick(10);
        set_in(1, 0);
        tick(2);
        chk("R1 still off after two edges", g, G_OFF);
        tick(1);
        chk("R1 forward on third edge", g, G_FWD);

        // Trip chopping with a second trip inside the off-time (R7, R8)
        tick(5);
        trip_flag = 1'b1;
        tick(1);
        trip_flag = 1'b0;
        chk("R7 chopping set at trip edge", chopping, 1);
        chk("R7 gates still on at trip edge", g, G_FWD);
        tick(1);
        chk("R7 gates off one edge after trip", g, G_OFF);
        tick(4);
        trip_flag = 1'b1;
        tick(1);
        trip_flag = 1'b0;
        tick(TOFF - 7);
        chk("R8 off-time still running", chopping, 1);
        chk("R7 gates off in off-time", g, G_OFF);
        tick(1);
        chk("R8 off-time not extended by second trip", chopping, 0);
        chk("R7 gates off at end of off-time", g, G_OFF);
        tick(1);
        chk("R7 diagonal resumes", g, G_FWD);

        // Over-temperature (R10)
        tick(5);
        overtemp_flag = 1'b1;
        tick(1);
        chk("R10 off at over-temperature", g, G_OFF);
        tick(10);
        chk("R10 off while flag held", g, G_OFF);
        overtemp_flag = 1'b0;
        tick(1);
        chk("R10 resumes after flag drops", g, G_FWD);

        // Undervoltage (R11)
        tick(5);
        undervolt_flag = 1'b1;
        tick(1);
        chk("R11 off at undervoltage", g, G_OFF);
        tick(10);
        chk("R11 off while flag held", g, G_OFF);
        undervolt_flag = 1'b0;
        tick(1);
        chk("R11 resumes after flag drops", g, G_FWD);

        // Short fault latch, idle entry timing, clear on exit (R9, R5)
        tick(5);
        short_flag = 1'b1;
        tick(1);
        short_flag = 1'b0;
        chk("R9 fault latched", fault_latched, 1);
        tick(1);
        chk("R9 gates off with fault", g, G_OFF);
        set_in(0, 1);
        tick(20);
        chk("R9 fault blocks reverse", g, G_OFF);
        set_in(0, 0);
        tick(20);
        set_in(1, 0);
        tick(20);
        chk("R9 short coast does not clear fault", fault_latched, 1);
        chk("R9 fault still blocks forward", g, G_OFF);
        set_in(0, 0);
        tick(STBY);
        chk("R5 not idle one edge early", idle_mode, 0);
        tick(3);
        chk("R5 idle after sustained coast", idle_mode, 1);
        set_in(1, 0);
        tick(3);
        chk("R9 fault cleared on idle exit", fault_latched, 0);
        chk("R6 idle left", idle_mode, 0);
        tick(WAKE + 2);
        chk("R9 drive restored after clear", g, G_FWD);

        // Idle entry aborted by a brief command (R5)
        set_in(0, 0);
        tick(STBY / 2);
        set_in(1, 0);
        tick(3);
        set_in(0, 0);
        tick(STBY / 2 + 10);
        chk("R5 entry aborted by command", idle_mode, 0);
        tick(STBY);
        chk("R5 idle after restarted count", idle_mode, 1);

        // Short on the same edge as the idle exit (R9)
        set_in(1, 0);
        tick(2);
        short_flag = 1'b1;
        tick(1);
        short_flag = 1'b0;
        chk("R6 exit taken with short", idle_mode, 0);
        chk("R9 short wins over exit", fault_latched, 1);
        tick(WAKE + 4);
        chk("R9 gates off after hold-off with fault", g, G_OFF);
        set_in(0, 0);
        tick(STBY + 5);
        chk("R5 idle again", idle_mode, 1);
        set_in(1, 0);
        tick(3);
        chk("R9 fault cleared by second exit", fault_latched, 0);
        tick(WAKE + 2);
        chk("R6 forward after second exit", g, G_FWD);

        // Constrained random phase (R2, R3, R7, R10, R11)
        begin
            logic [3:0] prev_g;
            logic prev_chop;
            int quiet;
            prev_g = g;
            prev_chop = chopping;
            quiet = 0;
            for (int h = 0; h < 260; h++) begin
                logic a, b;
                int len, mode;
                a = 1'($urandom_range(0, 1));
                b = 1'($urandom_range(0, 1));
                len = $urandom_range(4, 120);
                mode = $urandom_range(0, 5);
                set_in(a, b);
                quiet = 0;
                for (int c = 0; c < len; c++) begin
                    logic tr, ot, uv;
                    tr = (mode == 0) && ($urandom_range(0, 15) == 0);
                    ot = (mode == 1) && ($urandom_range(0, 23) == 0);
                    uv = (mode == 2) && ($urandom_range(0, 23) == 0);
                    trip_flag = tr;
                    overtemp_flag = ot;
                    undervolt_flag = uv;
                    tick(1);
                    trip_flag = 1'b0;
                    overtemp_flag = 1'b0;
                    undervolt_flag = 1'b0;
                    chk("R3 leg A exclusive", {31'd0, g[3] & g[2]}, 0);
                    chk("R3 leg B exclusive", {31'd0, g[1] & g[0]}, 0);
                    chk("R3 no direct swap",
                        {31'd0, (prev_g != G_OFF) && (g != G_OFF) && (g != prev_g)}, 0);
                    chk("R2 legal pattern", {31'd0, legal_pattern(g)}, 1);
                    if (ot) chk("R10 random over-temperature off", g, G_OFF);
                    if (uv) chk("R11 random undervoltage off", g, G_OFF);
                    if (prev_chop) chk("R7 random off-time gates off", g, G_OFF);
                    if (tr || ot || uv || idle_mode) quiet = 0;
                    else quiet++;
                    if (quiet > QUIET_MIN)
                        chk("R2 random steady pattern", g, exp_gates(a, b));
                    prev_g = g;
                    prev_chop = chopping;
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule